// File: doc/BRIEF.md
# Link Stress Pattern Generator and Bit Error Counter

This block drives a communication channel under test with a chosen 32-bit stress pattern and measures what comes back. The transmit side sends one pattern word per cycle while running, and marks the first word of each stream. The patterns target specific channel faults:
- bits stuck high or low;
- coupling between neighbouring lines;
- ground bounce on full-width swings;
- asymmetric transition timing;
- long runs of one level.

The receive side regenerates the same sequence in lockstep, starting at the stream marker. It compares each valid received word with the expected one and adds the number of differing bits to an error counter. It also counts the words it has compared. The ratio of the two counts estimates the bit error rate.

Control is through three command strobes (start, stop, clear) and a 4-bit pattern code. The code is captured when a stream starts and is held for the whole stream. The channel can have any latency: the checker aligns itself on the first-word marker, so words that arrive before that marker are ignored.

Top module: `link_bert`

## Requirements
- R1: After reset, txValid, txFirst and running are 0, and both counters read 0.
- R2: A start command while stopped sets running. From the next cycle, txValid is 1 every cycle. The first word carries txFirst=1, the later words carry txFirst=0, and the words follow the selected sequence from its index 0.
- R3: Code 0 alternates 0x00000000 and 0xFFFFFFFF. Code 1 alternates 0xAAAAAAAA and 0x55555555. Code 2 alternates 0xCCCCCCCC and 0x33333333. Each starts with the first value of its pair.
- R4: Code 3 starts at 0 and adds 0xAAAAAAAA modulo 2^32 for each following word.
- R5: Code 4 sends the word index n. Code 5 sends n in the upper 16 bits and (0 - n) modulo 2^16 in the lower 16 bits.
- R6: Code 6 sends a single one at bit position n mod 32. Code 7 sends the bitwise inverse of that word.
- R7: Codes 8 to 15 send all-zero words.
- R8: The pattern code is captured at an accepted start. A change of cfgPattern, or a further start command, while running has no effect on the transmitted sequence or on txFirst.
- R9: A stop command while running clears running, and txValid is 0 from the next cycle on.
- R10: The checker compares words only after it has seen a valid word with rxFirst=1 since the last accepted start. The marked word is compared against index 0 of the captured pattern, and each later valid word against the following index. Valid words before the marker change neither counter.
- R11: Each compared word adds 1 to wordCount and adds the popcount of (rxWord XOR expected) to errorCount.
- R12: A clear command zeroes both counters at the next edge. If a word arrives in the same cycle, the clear takes precedence.
- R13: Both counters saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgPattern | input | 4 | Pattern code, captured at start |
| cmdStart | input | 1 | Start strobe, accepted only while stopped |
| cmdStop | input | 1 | Stop strobe |
| cmdClear | input | 1 | Counter clear strobe |
| txWord | output | WORD_W | Transmitted pattern word |
| txValid | output | 1 | Transmit word valid |
| txFirst | output | 1 | Marks the first word of a stream |
| rxWord | input | WORD_W | Received word |
| rxValid | input | 1 | Received word valid |
| rxFirst | input | 1 | Received stream marker |
| wordCount | output | CNT_W | Compared word count |
| errorCount | output | CNT_W | Accumulated bit error count |
| running | output | 1 | Engine is sending |

## Verification
The bench keeps WORD_W at 32 and builds the block with CNT_W of 8, so a few hundred all-ones error words drive both counters into saturation. It sweeps all sixteen pattern codes over 40 words each, which takes the walking patterns past their wrap at bit 31. Every one of these runs is looped back through the checker. Further runs inject known bit masks into the loopback, insert a one-cycle channel delay, suppress the stream marker, and issue commands in the middle of a stream. All expected words and counts come from closed-form arithmetic on the word index.

// File: rtl/link_bert_pkg.sv
package link_bert_pkg;

  localparam int PAT_W = 4;

  localparam logic [PAT_W-1:0] PAT_SWING_FULL = 4'd0;
  localparam logic [PAT_W-1:0] PAT_SWING_ALT  = 4'd1;
  localparam logic [PAT_W-1:0] PAT_SWING_PAIR = 4'd2;
  localparam logic [PAT_W-1:0] PAT_ADD_ALT    = 4'd3;
  localparam logic [PAT_W-1:0] PAT_COUNT      = 4'd4;
  localparam logic [PAT_W-1:0] PAT_SPLIT      = 4'd5;
  localparam logic [PAT_W-1:0] PAT_WALK_ONE   = 4'd6;
  localparam logic [PAT_W-1:0] PAT_WALK_ZERO  = 4'd7;

  typedef struct packed {
    logic genLoad;    // restart transmit sequence at index 0
    logic genStep;    // advance transmit sequence
    logic chkUnlock;  // drop checker alignment
    logic cntClear;   // zero both counters
  } bert_strobe_t;

endpackage

// File: rtl/link_bert_pattern.sv
module link_bert_pattern
  import link_bert_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAT_W-1:0]  pattern,
  input  logic              restart,
  input  logic              step,
  output logic [WORD_W-1:0] seedWord,
  output logic [WORD_W-1:0] curWord
);

  localparam int HALF = WORD_W / 2;
  localparam logic [WORD_W-1:0] ALT_WORD  = {(WORD_W/2){2'b10}};
  localparam logic [WORD_W-1:0] PAIR_WORD = {(WORD_W/4){4'b1100}};
  localparam logic [WORD_W-1:0] ONE_WORD  = WORD_W'(1);

  logic [WORD_W-1:0] state;
  logic [WORD_W-1:0] baseWord;
  logic [WORD_W-1:0] nextWord;

  // index-0 word of each sequence
  always_comb begin
    case (pattern)
      PAT_SWING_ALT:  seedWord = ALT_WORD;
      PAT_SWING_PAIR: seedWord = PAIR_WORD;
      PAT_WALK_ONE:   seedWord = ONE_WORD;
      PAT_WALK_ZERO:  seedWord = ~ONE_WORD;
      default:        seedWord = '0;
    endcase
  end

  assign baseWord = restart ? seedWord : state;

  // successor of the base word
  always_comb begin
    case (pattern)
      PAT_SWING_FULL,
      PAT_SWING_ALT,
      PAT_SWING_PAIR: nextWord = ~baseWord;
      PAT_ADD_ALT:    nextWord = baseWord + ALT_WORD;
      PAT_COUNT:      nextWord = baseWord + ONE_WORD;
      PAT_SPLIT:      nextWord = {baseWord[WORD_W-1:HALF] + HALF'(1),
                                  baseWord[HALF-1:0] - HALF'(1)};
      PAT_WALK_ONE,
      PAT_WALK_ZERO:  nextWord = {baseWord[WORD_W-2:0], baseWord[WORD_W-1]};
      default:        nextWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= '0;
    else if (step)    state <= nextWord;
    else if (restart) state <= seedWord;
  end

  assign curWord = state;

endmodule

// File: rtl/link_bert_ctrl.sv
module link_bert_ctrl
  import link_bert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAT_W-1:0] cfgPattern,
  input  logic             cmdStart,
  input  logic             cmdStop,
  input  logic             cmdClear,
  output logic             running,
  output logic             firstWord,
  output logic [PAT_W-1:0] genPattern,
  output logic [PAT_W-1:0] heldPattern,
  output bert_strobe_t     strobe
);

  logic startAcc;

  assign startAcc = cmdStart && !running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running     <= 1'b0;
      firstWord   <= 1'b0;
      heldPattern <= '0;
    end else begin
      firstWord <= startAcc;
      if (startAcc) begin
        running     <= 1'b1;
        heldPattern <= cfgPattern;
      end else if (cmdStop) begin
        running <= 1'b0;
      end
    end
  end

  // the generator loads its seed in the same edge that captures the code
  assign genPattern       = startAcc ? cfgPattern : heldPattern;
  assign strobe.genLoad   = startAcc;
  assign strobe.genStep   = running;
  assign strobe.chkUnlock = startAcc;
  assign strobe.cntClear  = cmdClear;

  assert_code_held_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (!running || $stable(heldPattern)));

  assert_stop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (running && cmdStop) |=> !running);

  assert_start_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (!running && cmdStart) |=> (running && firstWord));

endmodule

// File: rtl/link_bert_path.sv
module link_bert_path
  import link_bert_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bert_strobe_t      strobe,
  input  logic [PAT_W-1:0]  genPattern,
  input  logic [PAT_W-1:0]  heldPattern,
  output logic [WORD_W-1:0] txWord,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxValid,
  input  logic              rxFirst,
  output logic [CNT_W-1:0]  wordCount,
  output logic [CNT_W-1:0]  errorCount
);

  localparam int POP_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] genSeed;
  logic [WORD_W-1:0] refSeed;
  logic [WORD_W-1:0] refWord;
  logic [WORD_W-1:0] expected;
  logic [WORD_W-1:0] diff;
  logic [POP_W-1:0]  bitErrs;
  logic              refMark;
  logic              locked;
  logic              compareEn;
  logic [CNT_W:0]    errSum;

  link_bert_pattern #(.WORD_W(WORD_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .pattern  (genPattern),
    .restart  (strobe.genLoad),
    .step     (strobe.genStep),
    .seedWord (genSeed),
    .curWord  (txWord)
  );

  assign refMark = rxValid && rxFirst;

  link_bert_pattern #(.WORD_W(WORD_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .pattern  (heldPattern),
    .restart  (refMark),
    .step     (rxValid),
    .seedWord (refSeed),
    .curWord  (refWord)
  );

  assign expected  = rxFirst ? refSeed : refWord;
  assign diff      = rxWord ^ expected;
  assign compareEn = rxValid && (rxFirst || locked) && !strobe.chkUnlock;

  always_comb begin
    bitErrs = '0;
    for (int i = 0; i < WORD_W; i++) bitErrs = bitErrs + POP_W'(diff[i]);
  end

  assign errSum = {1'b0, errorCount} + (CNT_W+1)'(bitErrs);

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.chkUnlock) locked <= 1'b0;
    else if (refMark)               locked <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.cntClear) begin
      wordCount  <= '0;
      errorCount <= '0;
    end else if (compareEn) begin
      if (wordCount != '1) wordCount <= wordCount + CNT_W'(1);
      errorCount <= errSum[CNT_W] ? '1 : errSum[CNT_W-1:0];
    end
  end

  assert_clear_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cntClear |=> (wordCount == '0 && errorCount == '0));

  assert_word_step_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.cntClear |=> (wordCount - $past(wordCount)) <= CNT_W'(1));

  assert_err_step_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.cntClear |=> (errorCount - $past(errorCount)) <= CNT_W'(WORD_W));

  assert_no_wrap_R13 : assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.cntClear && errorCount == '1) |=> errorCount == '1);

  assert_ignore_unaligned_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.chkUnlock && !strobe.cntClear) |=> $stable(wordCount));

endmodule

// File: rtl/link_bert.sv
module link_bert
  import link_bert_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfgPattern,
  input  logic              cmdStart,
  input  logic              cmdStop,
  input  logic              cmdClear,
  output logic [WORD_W-1:0] txWord,
  output logic              txValid,
  output logic              txFirst,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxValid,
  input  logic              rxFirst,
  output logic [CNT_W-1:0]  wordCount,
  output logic [CNT_W-1:0]  errorCount,
  output logic              running
);

  bert_strobe_t     strobe;
  logic [PAT_W-1:0] genPattern;
  logic [PAT_W-1:0] heldPattern;
  logic             firstWord;

  link_bert_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgPattern  (cfgPattern),
    .cmdStart    (cmdStart),
    .cmdStop     (cmdStop),
    .cmdClear    (cmdClear),
    .running     (running),
    .firstWord   (firstWord),
    .genPattern  (genPattern),
    .heldPattern (heldPattern),
    .strobe      (strobe)
  );

  link_bert_path #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .genPattern  (genPattern),
    .heldPattern (heldPattern),
    .txWord      (txWord),
    .rxWord      (rxWord),
    .rxValid     (rxValid),
    .rxFirst     (rxFirst),
    .wordCount   (wordCount),
    .errorCount  (errorCount)
  );

  assign txValid = running;
  assign txFirst = firstWord;

  assert_marker_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    txFirst |=> !txFirst);

  assert_marker_valid_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    txFirst |-> txValid);

endmodule

// File: tb/link_bert_tb.sv
module link_bert_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 8;
  localparam int RUN_LEN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfgPattern = '0;
  logic cmdStart = 1'b0, cmdStop = 1'b0, cmdClear = 1'b0;
  logic [WORD_W-1:0] txWord, rxWord;
  logic txValid, txFirst, rxValid, rxFirst, running;
  logic [CNT_W-1:0] wordCount, errorCount;

  logic [WORD_W-1:0] injectMask = '0;
  logic dropFirst = 1'b0, useDelay = 1'b0;
  logic [WORD_W-1:0] dWord;
  logic dValid, dFirst;

  int total = 0, failed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    dWord  <= txWord;
    dValid <= txValid;
    dFirst <= txFirst;
  end

  assign rxWord  = (useDelay ? dWord : txWord) ^ injectMask;
  assign rxValid = useDelay ? dValid : txValid;
  assign rxFirst = (useDelay ? dFirst : txFirst) && !dropFirst;

  link_bert #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgPattern(cfgPattern),
    .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdClear(cmdClear),
    .txWord(txWord), .txValid(txValid), .txFirst(txFirst),
    .rxWord(rxWord), .rxValid(rxValid), .rxFirst(rxFirst),
    .wordCount(wordCount), .errorCount(errorCount), .running(running)
  );

  function automatic logic [31:0] expWord(int pat, int n);
    logic [63:0] prod;
    logic [15:0] lo;
    case (pat)
      0: return (n % 2) ? 32'hFFFF_FFFF : 32'h0000_0000;
      1: return (n % 2) ? 32'h5555_5555 : 32'hAAAA_AAAA;
      2: return (n % 2) ? 32'h3333_3333 : 32'hCCCC_CCCC;
      3: begin prod = 64'(n) * 64'hAAAA_AAAA; return prod[31:0]; end
      4: return 32'(n);
      5: begin lo = 16'(0 - n); return {16'(n), lo}; end
      6: return 32'h1 << (n % 32);
      7: return ~(32'h1 << (n % 32));
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(int pat);
    if (pat <= 2) return "R3";
    if (pat == 3) return "R4";
    if (pat <= 5) return "R5";
    if (pat <= 7) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic startRun(input int pat);
    cfgPattern = 4'(pat);
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic stopRun();
    cmdStop = 1'b1;
    @(negedge clk);
    cmdStop = 1'b0;
  endtask

  task automatic clearCounts();
    cmdClear = 1'b1;
    @(negedge clk);
    cmdClear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int bad;
    logic [31:0] firstBad, firstExp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!txValid && !txFirst && !running && wordCount == 0 && errorCount == 0,
          "R1", {txValid, txFirst, running, wordCount, errorCount}, 0);

    // sweep every pattern code, looped back without errors
    for (int pat = 0; pat < 16; pat++) begin
      clearCounts();
      startRun(pat);
      check(running, "R2", running, 1);
      bad = 0; firstBad = '0; firstExp = '0;
      for (int n = 0; n < RUN_LEN; n++) begin
        if (n > 0) @(negedge clk);
        if (!txValid || txFirst != (n == 0) || txWord != expWord(pat, n)) begin
          if (bad == 0) begin firstBad = txWord; firstExp = expWord(pat, n); end
          bad++;
        end
      end
      check(bad == 0, reqOf(pat), firstBad, firstExp);
      stopRun();
      check(!txValid && !running, "R9", txValid, 0);
      check(wordCount == RUN_LEN && errorCount == 0, "R11",
            {wordCount, errorCount}, {8'(RUN_LEN), 8'd0});
    end

    // R10: a restart drops alignment; an unmarked stream is ignored
    clearCounts();
    dropFirst = 1'b1;
    startRun(4);
    repeat (10) @(negedge clk);
    stopRun();
    dropFirst = 1'b0;
    check(wordCount == 0 && errorCount == 0, "R10", wordCount, 0);

    // R10: one-cycle channel delay, alignment on the marker
    clearCounts();
    useDelay = 1'b1;
    startRun(7);
    repeat (24) @(negedge clk);
    stopRun();
    @(negedge clk);
    useDelay = 1'b0;
    check(wordCount == 25 && errorCount == 0, "R10", {wordCount, errorCount}, {8'd25, 8'd0});

    // R11: injected bit errors on words 5, 10, 20 -> 1 + 16 + 32
    clearCounts();
    startRun(4);
    for (int n = 0; n < 30; n++) begin
      if (n > 0) @(negedge clk);
      injectMask = (n == 5) ? 32'h1 : (n == 10) ? 32'hF0F0_F0F0 :
                   (n == 20) ? 32'hFFFF_FFFF : 32'h0;
    end
    stopRun();
    check(errorCount == 49 && wordCount == 30, "R11", {wordCount, errorCount}, {8'd30, 8'd49});

    // R8: code change and second start while running have no effect
    clearCounts();
    startRun(4);
    bad = 0;
    for (int n = 0; n < 20; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 3) begin cfgPattern = 4'd0; cmdStart = 1'b1; end
      if (n == 4) cmdStart = 1'b0;
      if (txWord != expWord(4, n) || txFirst != (n == 0)) bad++;
    end
    stopRun();
    check(bad == 0, "R8", bad, 0);
    check(wordCount == 20 && errorCount == 0, "R8", {wordCount, errorCount}, {8'd20, 8'd0});

    // R12: clear while words are arriving wins, counting resumes after
    clearCounts();
    injectMask = '1;
    startRun(0);
    repeat (3) @(negedge clk);
    check(wordCount == 3 && errorCount == 96, "R11", {wordCount, errorCount}, {8'd3, 8'd96});
    cmdClear = 1'b1;
    @(negedge clk);
    cmdClear = 1'b0;
    check(wordCount == 0 && errorCount == 0, "R12", {wordCount, errorCount}, 0);
    @(negedge clk);
    check(wordCount == 1 && errorCount == 32, "R12", {wordCount, errorCount}, {8'd1, 8'd32});
    stopRun();

    // R13: saturation of both counters
    clearCounts();
    startRun(1);
    repeat (299) @(negedge clk);
    stopRun();
    injectMask = '0;
    check(errorCount == 8'hFF, "R13", errorCount, 8'hFF);
    check(wordCount == 8'hFF, "R13", wordCount, 8'hFF);

    // R12: clear while idle
    clearCounts();
    check(wordCount == 0 && errorCount == 0, "R12", {wordCount, errorCount}, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule